// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether an incoming frame should be kept, based on its 48-bit destination MAC address. It runs the address through the Ethernet CRC-32, one byte per clock. It then uses the top bits of the resulting checksum as an index into a bit table. The stored bit at that index becomes the accept decision. Two 256-bit tables are kept. One serves addresses whose group bit is clear (individual addresses). The other serves addresses whose group bit is set (multicast and broadcast).

A mode input merges the two tables into one 512-entry table for group addresses, indexed by nine checksum bits. In this mode individual addresses can no longer be matched by hash. Software-side logic loads the tables through a simple word write port of 32-bit words. Each lookup works on a copy of the tables taken when the lookup starts. A table update made while a lookup is running therefore only affects the following address.

Top module: `dmac_hash_filter`

## Requirements
- R1: After reset, `done` and `accept` are 0 and every table bit is 0, so any lookup before the first write yields `accept`=0.
- R2: The checksum is the reflected CRC-32 (polynomial 0x04C11DB7, bit-reversed form 0xEDB88320). It starts from all ones and is inverted at the end. It runs over the address bytes `addr[47:40]` first down to `addr[7:0]` last, with each byte taken least significant bit first. Bits [31:24] of the result form the 8-bit hash H8, and bits [31:23] form the 9-bit hash H9.
- R3: The tables form one 512-bit space. Word w (0..15) written through the port holds entry 32*w+b in data bit b. Words 0..7 are the individual table and words 8..15 are the group table.
- R4: With `ext_mode`=0 and `addr[40]`=1 (group address), `accept` equals entry 256+H8.
- R5: With `ext_mode`=0 and `addr[40]`=0 (individual address), `accept` equals entry H8. Bits in the group table have no effect on such an address.
- R6: With `ext_mode`=1 and `addr[40]`=1, `accept` equals entry H9. Entries 0..255 come from the individual words.
- R7: With `ext_mode`=1 and `addr[40]`=0, `accept` is 0 whatever the tables hold.
- R8: When `addr_valid` is sampled high at a clock edge while idle, `done` is high for exactly one cycle, following the 6th edge after that one. `accept` carries the result only in that cycle and is 0 otherwise.
- R9: `addr_valid` sampled while a lookup is running is ignored. No extra `done` pulse follows, and the running result is unchanged.
- R10: A table write on the same edge as the accepted `addr_valid`, or during the lookup, does not change that lookup's result. The next lookup sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Start a lookup on `addr` |
| addr | input | 48 | Destination MAC address, first wire byte in [47:40] |
| ext_mode | input | 1 | 1 selects the merged 512-entry group table |
| tbl_we | input | 1 | Table word write enable |
| tbl_waddr | input | 4 | Table word index |
| tbl_wdata | input | 32 | Table word data |
| accept | output | 1 | Lookup result, valid with `done` |
| done | output | 1 | One-cycle end-of-lookup strobe |

## Verification
The hardest case to reach from the ports is a table write that falls inside a running lookup. The write must target exactly the bit that lookup will read, and it must land between the start edge and the result edge. The bench computes the hash of a chosen address itself and leaves that bit clear. It starts the lookup and writes the word holding that bit two cycles later. It then expects a reject followed by an accept on the repeated address. A second hard case is the upper half of the merged table. Here the bench searches addresses until it finds one whose nine-bit hash lies above 255 and one below, so that both halves are exercised.

// File: rtl/hashflt_pkg.sv
package hashflt_pkg;
  localparam int WORD_W     = 32;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte of reflected CRC, LSB of the byte first.
  function automatic logic [CRC_W-1:0] crc_byte_upd(input logic [CRC_W-1:0] c,
                                                    input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import hashflt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] base;

  always_comb base = load ? '1 : crc_q;

  always_ff @(posedge clk) begin
    if (rst)               crc_q <= '1;
    else if (load || step) crc_q <= crc_byte_upd(base, din);
  end

  // R2: a fresh load always starts from the all-ones seed
  a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
    load |=> crc_q == crc_byte_upd('1, $past(din)));
endmodule

// File: rtl/hash_bit_table.sv
module hash_bit_table #(
  parameter int NWORDS = 16,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(NWORDS),
  localparam int NBITS = NWORDS * WORD_W,
  localparam int IW    = $clog2(NBITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              snap_en,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_bit
);
  logic [NBITS-1:0] live;
  logic [NBITS-1:0] snap;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        live[w*WORD_W +: WORD_W] <= '0;
        snap[w*WORD_W +: WORD_W] <= '0;
      end else begin
        if (we && waddr == AW'(w)) live[w*WORD_W +: WORD_W] <= wdata;
        if (snap_en)               snap[w*WORD_W +: WORD_W] <= live[w*WORD_W +: WORD_W];
      end
    end
  end

  always_comb rd_bit = snap[rd_idx];

  // R10: the lookup copy only moves when a new lookup starts
  a_r10_snap_frozen: assert property (@(posedge clk) disable iff (rst)
    !snap_en |=> $stable(snap));
endmodule

// File: rtl/dmac_hash_filter.sv
module dmac_hash_filter
  import hashflt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int TBL_WORDS  = 16,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int WA_W      = $clog2(TBL_WORDS),
  localparam int IDX_W     = $clog2(TBL_WORDS * WORD_W),
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1),
  localparam int LAST      = ADDR_BYTES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_mode,
  input  logic              tbl_we,
  input  logic [WA_W-1:0]   tbl_waddr,
  input  logic [WORD_W-1:0] tbl_wdata,
  output logic              accept,
  output logic              done
);
  logic              busy, ext_q, grp_q, start, step, fin, tbl_bit;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic [7:0]        crc_in;
  logic [CRC_W-1:0]  crc_q, crc_fin;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    start  = addr_valid && !busy;
    step   = busy && cnt != CNT_W'(LAST);
    fin    = busy && cnt == CNT_W'(LAST);
    crc_in = start ? addr[ADDR_W-1 -: 8] : sh[ADDR_W-1 -: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cnt <= '0; sh <= '0; ext_q <= 1'b0; grp_q <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      sh    <= addr << 8;
      ext_q <= ext_mode;
      grp_q <= addr[ADDR_W-8];
    end else if (step) begin
      cnt <= cnt + 1'b1;
      sh  <= sh << 8;
    end else if (fin) begin
      busy <= 1'b0;
    end
  end

  crc_byte_engine u_crc (
    .clk(clk), .rst(rst), .load(start), .step(step), .din(crc_in), .crc_q(crc_q)
  );

  always_comb begin
    crc_fin = ~crc_q;
    if (ext_q) idx = crc_fin[CRC_W-1 -: IDX_W];
    else       idx = {grp_q, crc_fin[CRC_W-1 -: IDX_W-1]};
  end

  hash_bit_table #(.NWORDS(TBL_WORDS), .WORD_W(WORD_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .snap_en(start), .rd_idx(idx), .rd_bit(tbl_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; accept <= 1'b0;
    end else begin
      done   <= fin;
      accept <= fin && tbl_bit && !(ext_q && !grp_q);
    end
  end

  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: accept only with done
  a_r8_accept_gated: assert property (@(posedge clk) disable iff (rst)
    !done |-> !accept);
  // R7: merged mode never accepts an individual address
  a_r7_ext_ind_reject: assert property (@(posedge clk) disable iff (rst)
    done && ext_q && !grp_q |-> !accept);
  // R9: a request during a lookup leaves the captured context alone
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    busy && addr_valid |=> $stable(ext_q) && $stable(grp_q));
endmodule

// File: tb/test_dmac_hash_filter.sv
module test_dmac_hash_filter;
  logic clk = 1'b0, rst = 1'b1;
  logic addr_valid = 1'b0, ext_mode = 1'b0, tbl_we = 1'b0;
  logic [47:0] addr = '0;
  logic [3:0]  tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;
  logic accept, done;
  logic [511:0] mdl = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dmac_hash_filter i_dmac_hash_filter (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr), .ext_mode(ext_mode),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .accept(accept), .done(done)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 5; k >= 0; k--)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ a[k*8+i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  function automatic logic ref_acc(input logic [47:0] a, input logic ext);
    logic [31:0] c = ref_crc(a);
    if (ext) return a[40] ? mdl[c[31:23]] : 1'b0;
    return mdl[{a[40], c[31:24]}];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_word(input int w, input logic [31:0] d);
    @(negedge clk); tbl_we = 1; tbl_waddr = w[3:0]; tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
    mdl[w*32 +: 32] = d;
  endtask

  task automatic set_bit(input int idx, input logic v);
    logic [31:0] d = mdl[(idx/32)*32 +: 32];
    d[idx%32] = v;
    wr_word(idx/32, d);
  endtask

  // Lookup with optional mid-lookup write (at wr_at) and stray valid (at vld_at).
  task automatic lookup(input logic [47:0] a, input logic ext, input string req,
                        input int wr_at = -1, input int wr_idx = 0,
                        input int vld_at = -1);
    logic exp = ref_acc(a, ext);
    bit early = 0;
    @(negedge clk); addr = a; ext_mode = ext; addr_valid = 1;
    @(negedge clk); addr_valid = 0;
    for (int i = 1; i <= 5; i++) begin
      if (i == wr_at) begin
        logic [31:0] d = mdl[(wr_idx/32)*32 +: 32];
        d[wr_idx%32] = 1'b1;
        tbl_we = 1; tbl_waddr = 4'(wr_idx/32); tbl_wdata = d;
        mdl[(wr_idx/32)*32 +: 32] = d;
      end
      if (i == vld_at) begin addr = ~a; ext_mode = ~ext; addr_valid = 1; end
      @(negedge clk); tbl_we = 0; addr_valid = 0;
      if (done) early = 1;
    end
    check(!early, {req, " R8 no early done"}, early, 0);
    @(negedge clk);
    check(done === 1'b1, {req, " R8 done at 6th edge"}, done, 1);
    check(accept === exp, req, accept, exp);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done || accept) early = 1;
    end
    check(!early, {req, " R8/R9 single done"}, early, 0);
  endtask

  task automatic t_reset();
    check(done === 0 && accept === 0, "R1 reset outputs", {done, accept}, 0);
    lookup(48'h0100_5E00_0001, 0, "R1 empty table group");
    lookup(48'h0200_0000_0001, 0, "R1 empty table individual");
  endtask

  task automatic t_normal();
    logic [47:0] g = 48'h0100_5E7F_1234, u = 48'h0A1B_2C3D_4E5F;
    logic [7:0] hg = ref_crc(g)[31:24], hu = ref_crc(u)[31:24];
    set_bit(256 + hg, 1);
    lookup(g, 0, "R4 R3 group hit");
    set_bit(256 + hg, 0);
    lookup(g, 0, "R4 group cleared");
    set_bit(256 + hu, 1);
    lookup(u, 0, "R5 group bit ignored for individual");
    set_bit(hu, 1);
    lookup(u, 0, "R5 individual hit");
    set_bit(hu, 0); set_bit(256 + hu, 0);
  endtask

  task automatic t_ext();
    logic [47:0] lo = '0, hi = '0;
    bit got_lo = 0, got_hi = 0;
    for (int k = 0; k < 64 && !(got_lo && got_hi); k++) begin
      logic [47:0] a = 48'h3300_0000_0000 | 48'(k * 37 + 5);
      if (!ref_crc(a)[31] && !got_lo) begin lo = a; got_lo = 1; end
      if ( ref_crc(a)[31] && !got_hi) begin hi = a; got_hi = 1; end
    end
    check(got_lo && got_hi, "R6 address search", {got_lo, got_hi}, 3);
    set_bit(ref_crc(lo)[31:23], 1);
    lookup(lo, 1, "R6 lower half from individual words");
    lookup(lo, 0, "R4 same address normal mode");
    set_bit(ref_crc(hi)[31:23], 1);
    lookup(hi, 1, "R6 upper half");
    set_bit(ref_crc(hi)[31:23], 0);
    lookup(hi, 1, "R6 upper half cleared");
    set_bit(ref_crc(lo)[31:23], 0);
  endtask

  task automatic t_ext_ind();
    logic [47:0] u = 48'h0011_2233_4455;
    for (int w = 0; w < 16; w++) wr_word(w, 32'hFFFF_FFFF);
    lookup(u, 1, "R7 merged mode individual reject");
    lookup(u, 0, "R5 full table individual accept");
    for (int w = 0; w < 16; w++) wr_word(w, 32'h0);
  endtask

  task automatic t_busy();
    logic [47:0] g = 48'h0100_5E00_00FB;
    set_bit(256 + ref_crc(g)[31:24], 1);
    lookup(g, 0, "R9 stray valid during lookup", -1, 0, 2);
    set_bit(256 + ref_crc(g)[31:24], 0);
    lookup(g, 0, "R9 stray valid mid-lookup", -1, 0, 4);
  endtask

  task automatic t_midwrite();
    logic [47:0] g = 48'h0180_C200_000E;
    int ix = 256 + ref_crc(g)[31:24];
    logic exp0;
    set_bit(ix, 0);
    exp0 = 1'b0;
    // lookup computes expectation before the write is modelled
    lookup(g, 0, "R10 write during lookup not seen", 2, ix);
    check(mdl[ix] === 1'b1, "R10 model updated", mdl[ix], 1);
    lookup(g, 0, "R10 write seen by next lookup");
    check(exp0 == 1'b0, "R10 baseline", exp0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_ext();
    t_ext_ind();
    t_busy();
    t_midwrite();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule